// File: doc/BRIEF.md
# Register Writer-Order Dependency Tracker

This block records, for every architectural register of an in-order pipeline, which in-flight instructions still have to write that register. Each register keeps a short queue of writer sequence tags in program order, with the oldest writer at the head. The issue logic inserts an instruction's tag once per destination register. Retirement or squash logic removes the tag again, either by searching for it or by popping a register's head.

A single query port lets a stage ask four questions about one register for one requesting tag. It can ask whether the register may be read from the register file and whether it may be written. It can also ask which older writer can forward its result, and which writer behind the head has already executed and so can supply a bypass value. A separate mark port records that a tag has executed and in which cycle its result becomes ready. A free-running cycle counter inside the block gives the current cycle. Sequence tags are compared as plain unsigned numbers, so the smaller tag is the older instruction.

Top module: `regdep_tracker`

## Requirements
- R1: After reset, or one cycle after `clr` is high, every queue is empty. Every register then reports read and write permission, no forwarding source and no bypass source, and both error outputs are low.
- R2: An insert appends its tag at the tail of the queue of each valid destination. If both destinations name the same register, the tag is appended twice. The new entries start as not executed.
- R3: A remove takes effect only when the tag's has-entries flag is set. An insert sets this flag and an accepted remove clears it. For each valid destination, the remove deletes the first entry holding that tag and keeps the remaining entries in their order. A remove with a clear flag leaves every queue unchanged.
- R4: A remove-front pops the head of the named register's queue when the head holds the supplied tag. If the queue is empty or the head tag differs, the queue is left unchanged and `rmf_err` is high for one cycle after the command.
- R5: `q_can_read` is high when the queried queue is empty, or when `q_tag` is less than or equal to the head tag. `q_can_write` follows exactly the same rule.
- R6: The forwarding candidate is found by walking the queue from the head while the entries' tags are below `q_tag`. The candidate is the last entry passed, which is the youngest older writer. `fwd_valid` is high only when that candidate is executed and its ready cycle is strictly less than `cur_cycle`. `fwd_tag` is the candidate's tag when `fwd_valid` is high and 0 otherwise.
- R7: `byp_valid` is low when the queue holds fewer than two entries. Otherwise it reports the first executed entry from the second position onward. `byp_tag` is that entry's tag, or 0 when `byp_valid` is low.
- R8: If an insert would leave more than DEPTH entries in a register's queue, that queue is left unchanged and `ovf_err` is high for one cycle after the command.
- R9: A mark sets the executed flag of every stored entry holding the marked tag, in all registers, and records `mark_cycle` as the entry's ready cycle.
- R10: When a remove and an insert arrive in the same cycle, the remove is applied first. A full queue can therefore lose one entry and gain one in the same cycle without overflow.
- R11: `cur_cycle` is 0 while reset is high and increases by one on every clock edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all queues and flags |
| ins_valid | input | 1 | Insert command |
| ins_tag | input | 8 | Sequence tag to insert |
| ins_d0_vld | input | 1 | First destination is valid |
| ins_d0 | input | 5 | First destination register |
| ins_d1_vld | input | 1 | Second destination is valid |
| ins_d1 | input | 5 | Second destination register |
| rem_valid | input | 1 | Remove command |
| rem_tag | input | 8 | Sequence tag to remove |
| rem_d0_vld | input | 1 | First destination of the remove is valid |
| rem_d0 | input | 5 | First destination register of the remove |
| rem_d1_vld | input | 1 | Second destination of the remove is valid |
| rem_d1 | input | 5 | Second destination register of the remove |
| rmf_valid | input | 1 | Remove-front command |
| rmf_reg | input | 5 | Register whose head is popped |
| rmf_tag | input | 8 | Tag expected at that head |
| mark_valid | input | 1 | Mark-executed command |
| mark_tag | input | 8 | Tag that has executed |
| mark_cycle | input | 16 | Cycle in which its result is ready |
| q_reg | input | 5 | Queried register |
| q_tag | input | 8 | Requesting instruction's tag |
| q_can_read | output | 1 | Register-file read allowed |
| q_can_write | output | 1 | Register-file write allowed |
| fwd_valid | output | 1 | A forwarding source is available |
| fwd_tag | output | 8 | Tag of the forwarding source |
| byp_valid | output | 1 | A bypass source is available |
| byp_tag | output | 8 | Tag of the bypass source |
| cur_cycle | output | 16 | Free-running cycle count |
| ovf_err | output | 1 | Insert overflow, one cycle after the command |
| rmf_err | output | 1 | Failed remove-front, one cycle after the command |

## Verification
Every command takes effect at the rising edge on which it is sampled. The query outputs are combinational on the stored queues, so a query placed after that edge already sees the result. Both error flags are registered: each is high only in the cycle that follows the offending command and drops at the next edge. The bench drives commands and query inputs at the falling edge and keeps each command for exactly one rising edge. It sets up the query in the next low phase and compares half a phase later, which is exactly the window in which both the new queue state and the error pulse are visible. Ready-cycle checks read `cur_cycle` when a mark is issued. One check places the ready cycle equal to the counter value that follows, and the next cycle confirms that forwarding opens only once the counter has passed it.

// File: rtl/regdep_pkg.sv
`timescale 1ns/1ps
package regdep_pkg;
    localparam int TAG_W = 8;
    localparam int CYC_W = 16;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [CYC_W-1:0] cyc_t;

    // One pending writer in a register's queue
    typedef struct packed {
        tag_t tag;
        logic done;
        cyc_t rdy;
    } wr_ent_t;

    // Result of a source lookup
    typedef struct packed {
        logic vld;
        tag_t tag;
    } src_res_t;

    // Requester may proceed past a head writer when not younger than it
    function automatic logic not_younger(tag_t req, tag_t head);
        return req <= head;
    endfunction
endpackage

// File: rtl/rd_cycle_ctr.sv
`timescale 1ns/1ps
module rd_cycle_ctr
    import regdep_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output cyc_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= cur + cyc_t'(1);
    end

    // R11
    cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cur == $past(cur) + cyc_t'(1));
endmodule

// File: rtl/rd_wq.sv
`timescale 1ns/1ps
module rd_wq
    import regdep_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic [1:0]            rem_n,
    input  tag_t                  rem_tag,
    input  logic                  rmf_hit,
    input  tag_t                  rmf_tag,
    input  logic                  mark_v,
    input  tag_t                  mark_tag,
    input  cyc_t                  mark_cyc,
    input  logic [1:0]            ins_n,
    input  tag_t                  ins_tag,
    output wr_ent_t [DEPTH-1:0]   ents,
    output logic [CNT_W-1:0]      cnt,
    output logic                  ovf,
    output logic                  rmf_bad
);
    wr_ent_t [DEPTH-1:0] w;
    logic [CNT_W-1:0]    cnt_nxt;
    logic                found;
    int                  n;

    always_comb begin
        w       = ents;
        n       = int'(cnt);
        ovf     = 1'b0;
        rmf_bad = 1'b0;
        found   = 1'b0;
        // removal by tag, once per matching destination
        for (int k = 0; k < 2; k++) begin
            if (k < int'(rem_n)) begin
                found = 1'b0;
                for (int j = 0; j < DEPTH; j++) begin
                    if (!found && j < n && w[j].tag == rem_tag) found = 1'b1;
                    if (found && j < DEPTH - 1) w[j] = w[j+1];
                end
                if (found) n = n - 1;
            end
        end
        // head pop with tag check
        if (rmf_hit) begin
            if (n == 0 || w[0].tag != rmf_tag) begin
                rmf_bad = 1'b1;
            end else begin
                for (int j = 0; j < DEPTH - 1; j++) w[j] = w[j+1];
                n = n - 1;
            end
        end
        // executed marking of stored entries
        if (mark_v) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (j < n && w[j].tag == mark_tag) begin
                    w[j].done = 1'b1;
                    w[j].rdy  = mark_cyc;
                end
            end
        end
        // append at tail
        if (ins_n != 2'd0) begin
            if (n + int'(ins_n) > DEPTH) begin
                ovf = 1'b1;
            end else begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j >= n && j < n + int'(ins_n)) begin
                        w[j].tag  = ins_tag;
                        w[j].done = 1'b0;
                        w[j].rdy  = '0;
                    end
                end
                n = n + int'(ins_n);
            end
        end
        cnt_nxt = CNT_W'(n);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ents <= '0;
            cnt  <= '0;
        end else begin
            ents <= w;
            cnt  <= cnt_nxt;
        end
    end

    // R1
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0);
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= DEPTH);
    // R8
    ovf_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && rem_n == 2'd0 && !rmf_hit && !clr) |=> cnt == $past(cnt));
    // R4
    rmf_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rmf_bad && rem_n == 2'd0 && ins_n == 2'd0 && !clr) |=> cnt == $past(cnt));
endmodule

// File: rtl/rd_query.sv
`timescale 1ns/1ps
module rd_query
    import regdep_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  wr_ent_t [DEPTH-1:0] ents,
    input  logic [CNT_W-1:0]    cnt,
    input  tag_t                q_tag,
    input  cyc_t                cur,
    output logic                can_ok,
    output src_res_t            fwd,
    output src_res_t            byp
);
    wr_ent_t cand;
    logic    have, stop, bfound;
    tag_t    btag;

    always_comb begin
        can_ok = (cnt == '0) || not_younger(q_tag, ents[0].tag);

        have = 1'b0;
        stop = 1'b0;
        cand = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (!stop && j < int'(cnt)) begin
                if (ents[j].tag < q_tag) begin
                    have = 1'b1;
                    cand = ents[j];
                end else begin
                    stop = 1'b1;
                end
            end
        end
        fwd.vld = have && cand.done && (cand.rdy < cur);
        fwd.tag = fwd.vld ? cand.tag : '0;

        bfound = 1'b0;
        btag   = '0;
        for (int j = 1; j < DEPTH; j++) begin
            if (!bfound && j < int'(cnt) && ents[j].done) begin
                bfound = 1'b1;
                btag   = ents[j].tag;
            end
        end
        byp.vld = bfound;
        byp.tag = btag;
    end
endmodule

// File: rtl/regdep_tracker.sv
`timescale 1ns/1ps
module regdep_tracker
    import regdep_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DEPTH    = 4,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int NTAG    = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ins_valid,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic             ins_d0_vld,
    input  logic [IDX_W-1:0] ins_d0,
    input  logic             ins_d1_vld,
    input  logic [IDX_W-1:0] ins_d1,
    input  logic             rem_valid,
    input  logic [TAG_W-1:0] rem_tag,
    input  logic             rem_d0_vld,
    input  logic [IDX_W-1:0] rem_d0,
    input  logic             rem_d1_vld,
    input  logic [IDX_W-1:0] rem_d1,
    input  logic             rmf_valid,
    input  logic [IDX_W-1:0] rmf_reg,
    input  logic [TAG_W-1:0] rmf_tag,
    input  logic             mark_valid,
    input  logic [TAG_W-1:0] mark_tag,
    input  logic [CYC_W-1:0] mark_cycle,
    input  logic [IDX_W-1:0] q_reg,
    input  logic [TAG_W-1:0] q_tag,
    output logic             q_can_read,
    output logic             q_can_write,
    output logic             fwd_valid,
    output logic [TAG_W-1:0] fwd_tag,
    output logic             byp_valid,
    output logic [TAG_W-1:0] byp_tag,
    output logic [CYC_W-1:0] cur_cycle,
    output logic             ovf_err,
    output logic             rmf_err
);
    logic [NTAG-1:0]     has_ent;
    logic                rem_ok;
    wr_ent_t [DEPTH-1:0] ents_all [NUM_REGS];
    logic [CNT_W-1:0]    cnt_all  [NUM_REGS];
    logic [NUM_REGS-1:0] ovf_vec, rmf_vec;
    cyc_t                cur;
    logic                can_ok;
    src_res_t            fwd_r, byp_r;

    assign rem_ok = rem_valid && has_ent[rem_tag];

    rd_cycle_ctr u_ctr (.clk(clk), .rst(rst), .cur(cur));
    assign cur_cycle = cur;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic       rm0, rm1, in0, in1;
        logic [1:0] rem_n, ins_n;
        assign rm0   = rem_ok && rem_d0_vld && (rem_d0 == IDX_W'(r));
        assign rm1   = rem_ok && rem_d1_vld && (rem_d1 == IDX_W'(r));
        assign in0   = ins_valid && ins_d0_vld && (ins_d0 == IDX_W'(r));
        assign in1   = ins_valid && ins_d1_vld && (ins_d1 == IDX_W'(r));
        assign rem_n = {1'b0, rm0} + {1'b0, rm1};
        assign ins_n = {1'b0, in0} + {1'b0, in1};

        rd_wq #(.DEPTH(DEPTH)) u_wq (
            .clk(clk), .rst(rst), .clr(clr),
            .rem_n(rem_n), .rem_tag(rem_tag),
            .rmf_hit(rmf_valid && (rmf_reg == IDX_W'(r))), .rmf_tag(rmf_tag),
            .mark_v(mark_valid), .mark_tag(mark_tag), .mark_cyc(mark_cycle),
            .ins_n(ins_n), .ins_tag(ins_tag),
            .ents(ents_all[r]), .cnt(cnt_all[r]),
            .ovf(ovf_vec[r]), .rmf_bad(rmf_vec[r])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            has_ent <= '0;
            ovf_err <= 1'b0;
            rmf_err <= 1'b0;
        end else begin
            if (rem_ok)    has_ent[rem_tag] <= 1'b0;
            if (ins_valid) has_ent[ins_tag] <= 1'b1;
            ovf_err <= |ovf_vec;
            rmf_err <= |rmf_vec;
        end
    end

    rd_query #(.DEPTH(DEPTH)) u_q (
        .ents(ents_all[q_reg]), .cnt(cnt_all[q_reg]),
        .q_tag(q_tag), .cur(cur),
        .can_ok(can_ok), .fwd(fwd_r), .byp(byp_r)
    );

    assign q_can_read  = can_ok;
    assign q_can_write = can_ok;
    assign fwd_valid   = fwd_r.vld;
    assign fwd_tag     = fwd_r.tag;
    assign byp_valid   = byp_r.vld;
    assign byp_tag     = byp_r.tag;

    // R6
    fwd_older_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> fwd_tag < q_tag);
    // R5
    fwd_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> !q_can_read);
    // R7
    byp_depth_chk: assert property (@(posedge clk) disable iff (rst)
        byp_valid |-> int'(cnt_all[q_reg]) >= 2);
    // R4
    rmf_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (rmf_valid && !clr && cnt_all[rmf_reg] == '0) |=> rmf_err);
endmodule

// File: tb/tb_regdep_tracker.sv
`timescale 1ns/1ps
module tb_regdep_tracker;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic ins_valid = 0, ins_d0_vld = 0, ins_d1_vld = 0;
    logic [7:0] ins_tag = 0;
    logic [4:0] ins_d0 = 0, ins_d1 = 0;
    logic rem_valid = 0, rem_d0_vld = 0, rem_d1_vld = 0;
    logic [7:0] rem_tag = 0;
    logic [4:0] rem_d0 = 0, rem_d1 = 0;
    logic rmf_valid = 0;
    logic [4:0] rmf_reg = 0;
    logic [7:0] rmf_tag = 0;
    logic mark_valid = 0;
    logic [7:0] mark_tag = 0;
    logic [15:0] mark_cycle = 0;
    logic [4:0] q_reg = 0;
    logic [7:0] q_tag = 0;
    logic q_can_read, q_can_write, fwd_valid, byp_valid, ovf_err, rmf_err;
    logic [7:0] fwd_tag, byp_tag;
    logic [15:0] cur_cycle;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    regdep_tracker dut (
        .clk(clk), .rst(rst), .clr(clr),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_d0_vld(ins_d0_vld), .ins_d0(ins_d0),
        .ins_d1_vld(ins_d1_vld), .ins_d1(ins_d1),
        .rem_valid(rem_valid), .rem_tag(rem_tag), .rem_d0_vld(rem_d0_vld), .rem_d0(rem_d0),
        .rem_d1_vld(rem_d1_vld), .rem_d1(rem_d1),
        .rmf_valid(rmf_valid), .rmf_reg(rmf_reg), .rmf_tag(rmf_tag),
        .mark_valid(mark_valid), .mark_tag(mark_tag), .mark_cycle(mark_cycle),
        .q_reg(q_reg), .q_tag(q_tag),
        .q_can_read(q_can_read), .q_can_write(q_can_write),
        .fwd_valid(fwd_valid), .fwd_tag(fwd_tag), .byp_valid(byp_valid), .byp_tag(byp_tag),
        .cur_cycle(cur_cycle), .ovf_err(ovf_err), .rmf_err(rmf_err)
    );

    typedef struct {
        int    r;
        int    t;
        bit    can;
        bit    fv;
        int    ft;
        bit    bv;
        int    bt;
        bit    ovf;
        bit    rmf;
        string req;
    } exp_t;
    exp_t sb[$];

    // driver: set up a query and queue its expectation, hold for one cycle
    task automatic chk(int r, int t, bit can, bit fv, int ft, bit bv, int bt,
                       bit ovf, bit rmf, string req);
        exp_t e;
        q_reg = 5'(r);
        q_tag = 8'(t);
        e = '{r, t, can, fv, ft, bv, bt, ovf, rmf, req};
        sb.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare in the low phase after the query was set up
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (q_can_read !== e.can || q_can_write !== e.can ||
                    fwd_valid !== e.fv || fwd_tag !== 8'(e.ft) ||
                    byp_valid !== e.bv || byp_tag !== 8'(e.bt) ||
                    ovf_err !== e.ovf || rmf_err !== e.rmf) begin
                    failures++;
                    $display("FAIL %s reg=%0d tag=%0d actual rd=%0b wr=%0b fwd=%0b/%0d byp=%0b/%0d ovf=%0b rmf=%0b expected rd=%0b fwd=%0b/%0d byp=%0b/%0d ovf=%0b rmf=%0b",
                        e.req, e.r, e.t, q_can_read, q_can_write, fwd_valid, fwd_tag,
                        byp_valid, byp_tag, ovf_err, rmf_err,
                        e.can, e.fv, e.ft, e.bv, e.bt, e.ovf, e.rmf);
                end
            end
        end
    end

    task automatic ins(int tag, bit v0, int d0, bit v1, int d1);
        ins_valid = 1; ins_tag = 8'(tag);
        ins_d0_vld = v0; ins_d0 = 5'(d0); ins_d1_vld = v1; ins_d1 = 5'(d1);
        @(negedge clk);
        ins_valid = 0; ins_d0_vld = 0; ins_d1_vld = 0;
    endtask

    task automatic rem(int tag, bit v0, int d0, bit v1, int d1);
        rem_valid = 1; rem_tag = 8'(tag);
        rem_d0_vld = v0; rem_d0 = 5'(d0); rem_d1_vld = v1; rem_d1 = 5'(d1);
        @(negedge clk);
        rem_valid = 0; rem_d0_vld = 0; rem_d1_vld = 0;
    endtask

    task automatic rem_ins(int rtag, int rd, int itag, int id);
        rem_valid = 1; rem_tag = 8'(rtag); rem_d0_vld = 1; rem_d0 = 5'(rd);
        ins_valid = 1; ins_tag = 8'(itag); ins_d0_vld = 1; ins_d0 = 5'(id);
        @(negedge clk);
        rem_valid = 0; rem_d0_vld = 0; ins_valid = 0; ins_d0_vld = 0;
    endtask

    task automatic pop(int r, int tag);
        rmf_valid = 1; rmf_reg = 5'(r); rmf_tag = 8'(tag);
        @(negedge clk);
        rmf_valid = 0;
    endtask

    task automatic mark(int tag, logic [15:0] cyc);
        mark_valid = 1; mark_tag = 8'(tag); mark_cycle = cyc;
        @(negedge clk);
        mark_valid = 0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk(3, 10, 1, 0, 0, 0, 0, 0, 0, "R1 reset");

        // R11 counter steps by one
        c = cur_cycle;
        @(negedge clk);
        checks++;
        if (cur_cycle !== c + 16'd1) begin
            failures++;
            $display("FAIL R11 actual=%0d expected=%0d", cur_cycle, c + 16'd1);
        end

        // R2 appends: reg3 [10,20,30], reg7 [20]
        ins(10, 1, 3, 0, 0);
        ins(20, 1, 3, 1, 7);
        ins(30, 1, 3, 0, 0);
        chk(3, 10, 1, 0, 0, 0, 0, 0, 0, "R5 equal head");
        chk(3, 25, 0, 0, 0, 0, 0, 0, 0, "R2 R6 older not executed");
        chk(7, 20, 1, 0, 0, 0, 0, 0, 0, "R2 R7 single entry");

        // R9 R6 strict ready cycle
        c = cur_cycle;
        mark(20, c + 16'd1);
        chk(3, 25, 0, 0, 0, 1, 20, 0, 0, "R6 ready equals current");
        chk(3, 25, 0, 1, 20, 1, 20, 0, 0, "R6 ready passed");
        chk(7, 25, 0, 1, 20, 0, 0, 0, 0, "R9 all matching entries");
        chk(3, 35, 0, 0, 0, 1, 20, 0, 0, "R6 youngest older");

        // R4 remove-front
        pop(3, 20);
        chk(3, 10, 1, 0, 0, 1, 20, 0, 1, "R4 head mismatch");
        pop(3, 10);
        chk(3, 15, 1, 0, 0, 0, 0, 0, 0, "R4 head popped");
        pop(9, 1);
        chk(9, 1, 1, 0, 0, 0, 0, 0, 1, "R4 empty queue");

        // R3 remove by tag
        rem(20, 1, 3, 1, 7);
        chk(7, 50, 1, 0, 0, 0, 0, 0, 0, "R3 removed reg7");
        chk(3, 50, 0, 0, 0, 0, 0, 0, 0, "R3 reg3 left 30");
        mark(30, 16'd0);
        chk(3, 50, 0, 1, 30, 0, 0, 0, 0, "R7 one entry no bypass");

        // R3 remove ignored once flag cleared
        ins(40, 1, 4, 1, 5);
        rem(40, 1, 4, 0, 0);
        rem(40, 1, 5, 0, 0);
        chk(5, 50, 0, 0, 0, 0, 0, 0, 0, "R3 ignored remove");
        chk(4, 50, 1, 0, 0, 0, 0, 0, 0, "R3 accepted remove");

        // R8 overflow on reg12
        ins(1, 1, 12, 0, 0);
        ins(2, 1, 12, 0, 0);
        ins(3, 1, 12, 0, 0);
        ins(4, 1, 12, 1, 12);
        chk(12, 100, 0, 0, 0, 0, 0, 1, 0, "R8 double insert overflow");
        ins(5, 1, 12, 0, 0);
        mark(5, 16'd0);
        chk(12, 100, 0, 1, 5, 1, 5, 0, 0, "R8 R2 queue unchanged then filled");
        ins(6, 1, 12, 0, 0);
        chk(12, 100, 0, 1, 5, 1, 5, 1, 0, "R8 full overflow");

        // R10 remove before insert on a full queue -> [2,3,5,7]
        rem_ins(1, 12, 7, 12);
        chk(12, 100, 0, 0, 0, 1, 5, 0, 0, "R10 swap on full");
        chk(12, 2, 1, 0, 0, 1, 5, 0, 0, "R10 R5 new head");

        // R3 middle removal keeps order -> [2,5,7]
        mark(3, 16'd0);
        rem(3, 1, 12, 0, 0);
        chk(12, 4, 0, 0, 0, 1, 5, 0, 0, "R3 middle removed");
        chk(12, 6, 0, 1, 5, 1, 5, 0, 0, "R6 after middle removal");

        // R1 clear
        clr = 1;
        @(negedge clk);
        clr = 0;
        chk(12, 100, 1, 0, 0, 0, 0, 0, 0, "R1 clear reg12");
        chk(3, 50, 1, 0, 0, 0, 0, 0, 0, "R1 clear reg3");

        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule